// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator

This block collects the interrupt lines of a USB OTG controller into two register groups that a host CPU reaches over a simple 32-bit register bus. The endpoint group holds one transmit line per endpoint and one receive line per non-control endpoint. The core group holds the controller's nine event lines. Each group has a raw source register that latches hardware events. Software can write ones to a set alias or a clear alias of that register, and it has a matching mask register with its own set and clear aliases. A read-only view shows source AND mask. Software can inject an event, such as a VBUS-drive change, through the set alias.

The CPU sees one registered, level interrupt line. The line goes high when any unmasked source is pending and the block is armed. Raising the line disarms the block. After the pending condition drains, the line cannot rise again until software writes the end-of-interrupt register, whatever the value written. A soft-reset bit in the control register returns all wrapper state to its reset values. The revision register returns a non-zero constant, so a read of zero shows that the block is absent or unclocked.

Top module: `usb_irq_agg`

## Requirements
- R1: Offset 0x00 reads the constant 0x0001_0A00. Reserved offsets 0x10 and 0x5C, and any unmapped offset, read 0.
- R2: A read request is answered on `bus_rdata` with `bus_rvalid` high in the cycle after the request, and `bus_rvalid` is low in every other cycle.
- R3: In the endpoint source register (0x20), `ep_tx_i[n]` latches into bit n (n = 0..15) and `ep_rx_i[n]` latches into bit 16+n (n = 1..15). Bit 16 always reads 0, even after a one is written to it through the set alias.
- R4: In the core source register (0x40), `core_evt_i[k]` latches into bit 16+k (k = 0..8). Bit 24 is the VBUS-drive-change event. All other bits read 0.
- R5: A write to a set alias (0x24, 0x44) sets the source bits written as one. A write to a clear alias (0x28, 0x48) clears them. Zero bits leave the source unchanged. Reads of either alias return the source register.
- R6: The mask set aliases (0x30, 0x50) and mask clear aliases (0x34, 0x54) update the masks, which read back at 0x2C and 0x4C and at their aliases. Direct writes to 0x20, 0x2C, 0x40 and 0x4C are ignored.
- R7: The masked views at 0x38 and 0x58 read source AND mask of their group.
- R8: If a hardware event and a clear-alias write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` rises one cycle after a masked bit first becomes pending while the block is armed. It stays low while nothing is pending.
- R10: Once raised, `irq_o` stays high while anything is pending and drops when nothing is. After it has been raised, it does not rise again until a write to 0x60 with any data. After that write, it rises one cycle later if anything is pending.
- R11: Writing 1 to bit 0 of control (0x04) clears sources, masks and `irq_o` at that clock edge and re-arms the block. Writing 0 has no effect. Control reads 0.
- R12: Status (0x08) reads bit 0 = any masked bit pending and bit 1 = armed. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ep_tx_i | input | 16 | Endpoint transmit event pulses |
| ep_rx_i | input | 16 | Endpoint receive event pulses (bit 0 unused) |
| core_evt_i | input | 9 | Controller core event pulses |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Two functions can hit the same source bit in one cycle: a hardware event and a software clear-alias write. The bench drives `core_evt_i[8]` in the same cycle as a write of bit 24 to the core clear alias, then reads the core source back and expects bit 24 to still be set. A second same-cycle pair is a mask-set write that creates a pending bit while the block is armed. The bench judges it by sampling `irq_o` in the cycle after the write, when it must still be low, and in the cycle after that, when it must be high.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  // Word offsets (byte offset >> 2)
  localparam logic [5:0] W_REV      = 6'h00;
  localparam logic [5:0] W_CTRL     = 6'h01;
  localparam logic [5:0] W_STAT     = 6'h02;
  localparam logic [5:0] W_EP_SRC   = 6'h08;
  localparam logic [5:0] W_EP_SSET  = 6'h09;
  localparam logic [5:0] W_EP_SCLR  = 6'h0A;
  localparam logic [5:0] W_EP_MSK   = 6'h0B;
  localparam logic [5:0] W_EP_MSET  = 6'h0C;
  localparam logic [5:0] W_EP_MCLR  = 6'h0D;
  localparam logic [5:0] W_EP_MSKD  = 6'h0E;
  localparam logic [5:0] W_CO_SRC   = 6'h10;
  localparam logic [5:0] W_CO_SSET  = 6'h11;
  localparam logic [5:0] W_CO_SCLR  = 6'h12;
  localparam logic [5:0] W_CO_MSK   = 6'h13;
  localparam logic [5:0] W_CO_MSET  = 6'h14;
  localparam logic [5:0] W_CO_MCLR  = 6'h15;
  localparam logic [5:0] W_CO_MSKD  = 6'h16;
  localparam logic [5:0] W_EOI      = 6'h18;

  typedef struct packed {
    logic src_set;
    logic src_clr;
    logic msk_set;
    logic msk_clr;
  } grp_we_t;
endpackage

// File: rtl/usbirq_group.sv
module usbirq_group #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic [W-1:0]          hw_evt,
  input  usbirq_pkg::grp_we_t   we,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          src_q,
  output logic [W-1:0]          msk_q,
  output logic [W-1:0]          masked
);
  logic [W-1:0] set_v, clr_v, mset_v, mclr_v, src_n, msk_n;

  always_comb begin
    set_v  = we.src_set ? wdata : '0;
    clr_v  = we.src_clr ? wdata : '0;
    mset_v = we.msk_set ? wdata : '0;
    mclr_v = we.msk_clr ? wdata : '0;
    // hardware events are OR-ed after the clear so they are never lost
    src_n  = (((src_q | set_v) & ~clr_v) | hw_evt) & IMPL;
    msk_n  = ((msk_q | mset_v) & ~mclr_v) & IMPL;
    masked = src_q & msk_q;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      src_q <= src_n;
      msk_q <= msk_n;
    end
  end

  // R8: an event on an implemented bit is latched even under a clear
  a_r8_hw_wins: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && ((hw_evt & IMPL) != '0)) |=>
      ((src_q & $past(hw_evt & IMPL)) == $past(hw_evt & IMPL)));

  // R6: the mask only moves on a mask alias write or soft reset
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && !we.msk_set && !we.msk_clr) |=> $stable(msk_q));
endmodule

// File: rtl/usbirq_gate.sv
module usbirq_gate (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic pending,
  input  logic eoi,
  output logic irq_q,
  output logic armed_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq_q <= pending & (irq_q | armed_q);
      if (eoi)                   armed_q <= 1'b1;
      else if (armed_q && pending) armed_q <= 1'b0;
    end
  end

  // R10: without re-arming the line cannot rise
  a_r10_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !eoi) |=> !$rose(irq_q));

  // R9: a rising line implies the block was armed
  a_r9_rise_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(armed_q));

  // R11: soft reset drops the line and re-arms
  a_r11_soft_rst: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!irq_q && armed_q));
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg #(
  parameter int          N_EP     = 16,
  parameter int          N_CORE   = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h0001_0A00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [N_EP-1:0]   ep_tx_i,
  input  logic [N_EP-1:0]   ep_rx_i,
  input  logic [N_CORE-1:0] core_evt_i,
  output logic              irq_o
);
  import usbirq_pkg::*;

  localparam int RX_LSB = 16;

  function automatic logic [DW-1:0] ep_impl_f();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < N_EP; i++) begin
      m[i] = 1'b1;
      if (i > 0) m[RX_LSB+i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] core_impl_f();
    logic [DW-1:0] m = '0;
    for (int k = 0; k < N_CORE; k++) m[CORE_LSB+k] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] EP_IMPL   = ep_impl_f();
  localparam logic [DW-1:0] CORE_IMPL = core_impl_f();

  logic [5:0]    widx;
  logic          wr, rd, soft_rst, eoi, pending, armed;
  grp_we_t       ep_we, co_we;
  logic [DW-1:0] ep_hw, co_hw;
  logic [DW-1:0] ep_src, ep_msk, ep_mskd, co_src, co_msk, co_mskd;
  logic [DW-1:0] rd_mux;

  assign widx = bus_addr[7:2];
  assign wr   = bus_valid &  bus_write;
  assign rd   = bus_valid & ~bus_write;

  always_comb begin
    ep_hw = '0;
    co_hw = '0;
    for (int i = 0; i < N_EP; i++) begin
      ep_hw[i] = ep_tx_i[i];
      if (i > 0) ep_hw[RX_LSB+i] = ep_rx_i[i];
    end
    for (int k = 0; k < N_CORE; k++) co_hw[CORE_LSB+k] = core_evt_i[k];
  end

  always_comb begin
    ep_we.src_set = wr && (widx == W_EP_SSET);
    ep_we.src_clr = wr && (widx == W_EP_SCLR);
    ep_we.msk_set = wr && (widx == W_EP_MSET);
    ep_we.msk_clr = wr && (widx == W_EP_MCLR);
    co_we.src_set = wr && (widx == W_CO_SSET);
    co_we.src_clr = wr && (widx == W_CO_SCLR);
    co_we.msk_set = wr && (widx == W_CO_MSET);
    co_we.msk_clr = wr && (widx == W_CO_MCLR);
    soft_rst      = wr && (widx == W_CTRL) && bus_wdata[0];
    eoi           = wr && (widx == W_EOI);
  end

  usbirq_group #(.W(DW), .IMPL(EP_IMPL)) u_ep (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .hw_evt(ep_hw),
    .we(ep_we), .wdata(bus_wdata),
    .src_q(ep_src), .msk_q(ep_msk), .masked(ep_mskd));

  usbirq_group #(.W(DW), .IMPL(CORE_IMPL)) u_core (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .hw_evt(co_hw),
    .we(co_we), .wdata(bus_wdata),
    .src_q(co_src), .msk_q(co_msk), .masked(co_mskd));

  assign pending = (ep_mskd != '0) || (co_mskd != '0);

  usbirq_gate u_gate (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .pending(pending),
    .eoi(eoi), .irq_q(irq_o), .armed_q(armed));

  always_comb begin
    unique case (widx)
      W_REV:                               rd_mux = REV_ID;
      W_STAT:                              rd_mux = {30'd0, armed, pending};
      W_EP_SRC, W_EP_SSET, W_EP_SCLR:      rd_mux = ep_src;
      W_EP_MSK, W_EP_MSET, W_EP_MCLR:      rd_mux = ep_msk;
      W_EP_MSKD:                           rd_mux = ep_mskd;
      W_CO_SRC, W_CO_SSET, W_CO_SCLR:      rd_mux = co_src;
      W_CO_MSK, W_CO_MSET, W_CO_MCLR:      rd_mux = co_msk;
      W_CO_MSKD:                           rd_mux = co_mskd;
      default:                             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  // R2: every read request is answered exactly one cycle later
  a_r2_rvalid: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid);
endmodule

// File: tb/tb_usb_irq_agg.sv
module tb_usb_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] ep_tx_i = '0, ep_rx_i = '0;
  logic [8:0]  core_evt_i = '0;
  logic        irq_o;

  int checks = 0, errors = 0, reads_sent = 0, reads_seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_agg dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ep_tx_i(ep_tx_i), .ep_rx_i(ep_rx_i),
    .core_evt_i(core_evt_i), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // driver: issue read and push expectation into the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req); reads_sent++;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      reads_seen++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected rvalid expected=none");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R9 reset irq", {31'd0, irq_o}, 32'd0);
    rd(8'h00, 32'h0001_0A00, "R1 revision");
    rd(8'h10, 32'h0, "R1 reserved 0x10");
    rd(8'h5C, 32'h0, "R1 reserved 0x5C");
    rd(8'h7C, 32'h0, "R1 unmapped");
    rd(8'h08, 32'h2, "R12 status idle");
    rd(8'h04, 32'h0, "R11 control reads 0");

    // R3 endpoint layout
    ep_tx_i[3] = 1'b1; ep_rx_i[5] = 1'b1; ep_rx_i[0] = 1'b1;
    tick(1);
    ep_tx_i = '0; ep_rx_i = '0;
    rd(8'h20, 32'h0020_0008, "R3 ep layout");
    check("R9 masked off no irq", {31'd0, irq_o}, 32'd0);
    wr(8'h24, 32'h0001_0000);
    rd(8'h20, 32'h0020_0008, "R3 bit16 stays 0");

    // R5 set/clear aliases
    wr(8'h24, 32'h0000_0100);
    rd(8'h24, 32'h0020_0108, "R5 set alias readback");
    wr(8'h28, 32'h0000_0008);
    rd(8'h28, 32'h0020_0100, "R5 clear alias");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0020_0100, "R6 direct src write ignored");

    // R4 core layout
    core_evt_i[8] = 1'b1;
    tick(1);
    core_evt_i = '0;
    rd(8'h40, 32'h0100_0000, "R4 vbus drive bit24");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h01FF_0000, "R4 core implemented bits");

    // R6 / R9 mask set creates pending while armed
    wr(8'h30, 32'h0000_0100);
    check("R9 irq not yet", {31'd0, irq_o}, 32'd0);
    tick(1);
    check("R9 irq one cycle later", {31'd0, irq_o}, 32'd1);
    rd(8'h2C, 32'h0000_0100, "R6 ep mask");
    wr(8'h4C, 32'h0000_FFFF);
    rd(8'h4C, 32'h0, "R6 direct mask write ignored");
    rd(8'h38, 32'h0000_0100, "R7 ep masked view");
    rd(8'h08, 32'h1, "R12 pending not armed");

    // R10 EOI gating
    wr(8'h28, 32'h0000_0100);
    tick(1);
    check("R10 irq drops", {31'd0, irq_o}, 32'd0);
    wr(8'h24, 32'h0000_0100);
    tick(3);
    check("R10 no rearm without EOI", {31'd0, irq_o}, 32'd0);
    wr(8'h60, 32'h0);
    check("R10 irq after EOI not yet", {31'd0, irq_o}, 32'd0);
    tick(1);
    check("R10 irq after EOI", {31'd0, irq_o}, 32'd1);

    // R8 same-cycle hw event vs clear
    wr(8'h50, 32'h0100_0000);
    core_evt_i[8] = 1'b1;
    wr(8'h48, 32'h0100_0000);
    core_evt_i = '0;
    rd(8'h40, 32'h01FF_0000, "R8 hw wins over clear");
    wr(8'h48, 32'h0001_0000);
    rd(8'h40, 32'h01FE_0000, "R5 core clear");
    rd(8'h58, 32'h0100_0000, "R7 core masked view");
    wr(8'h54, 32'h0100_0000);
    rd(8'h50, 32'h0, "R6 core mask clear");
    check("R10 irq held while pending", {31'd0, irq_o}, 32'd1);

    // R11 soft reset
    wr(8'h04, 32'h0);
    rd(8'h20, 32'h0020_0100, "R11 control 0 no effect");
    wr(8'h04, 32'h1);
    check("R11 irq cleared", {31'd0, irq_o}, 32'd0);
    rd(8'h20, 32'h0, "R11 ep src cleared");
    rd(8'h2C, 32'h0, "R11 ep mask cleared");
    rd(8'h40, 32'h0, "R11 core src cleared");
    rd(8'h08, 32'h2, "R11 rearmed status");

    tick(2);
    check("R2 all reads answered", reads_seen, reads_sent);
    done = 1'b1;
    finish_run();
  end
endmodule